// File: doc/BRIEF.md
# I2C Register-Bank Slave

This block is a serial-bus slave that exposes a small register bank to a bus master. It watches an I2C clock and data pair that are sampled on a much faster system clock. It recognises START and STOP conditions and answers a 7-bit address. That address is a fixed upper nibble followed by three strap inputs. After a write address, the first byte sets a command register, which holds a 4-bit pointer and an auto-increment flag. Later bytes write or read the register that the pointer selects. When the flag is set, the pointer moves on after every byte.

The bank holds ten 8-bit entries. The two lowest entries are read-only snapshots of a 16-bit external pin vector. The next four hold two rate/duty pairs, and the last four are lane selectors. The eight writable registers are presented in parallel on `cfg_o`. A one-cycle strobe per register marks each write. The block has no clock stretching, no input glitch filter and no general-call address.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its seven upper bits equal binary 1100 followed by `strap_i[2:0]`. Bit 0 of the address byte selects read (1) or write (0). Any other address gets no acknowledge, and the slave then stays silent until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bus activity before the first START is ignored. A START seen in the middle of a byte begins a new address phase.
- R3: The first byte after a matching write address is the command. Bits 3:0 load the pointer, bit 4 loads the auto-increment flag, and bits 7:5 are discarded. Both fields reset to zero.
- R4: The register map is: pointer 0 is pins 7:0, 1 is pins 15:8, 2 is rate A (reset FFh), 3 is duty A (reset 80h), 4 is rate B (reset FFh), 5 is duty B (reset 80h), and 6 to 9 are selectors 0 to 3 (reset 55h). Byte k of `cfg_o` (bits 8k+7:8k) holds register 2+k.
- R5: A data byte written while the pointer is 2 to 9 replaces that register. `wr_stb_o[pointer-2]` pulses for exactly one clock as the new value appears. At most one strobe bit is high at a time.
- R6: With the flag set, the pointer advances after every data byte read or written. It goes from 9, or from any value 10 to 15, back to 0. With the flag clear, the pointer does not move.
- R7: Data bytes written while the pointer is 0, 1 or 10 to 15 are acknowledged but change no register and raise no strobe.
- R8: Read data is sent MSB first. A read with the pointer at 10 to 15 returns 00h.
- R9: A pin byte is captured at the falling SCL edge that ends the acknowledge clock just before that byte is sent. A pin change later in that byte does not alter it.
- R10: If the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START or STOP.
- R11: The slave pulls SDA low through the ninth clock after a matching address and after every byte it receives in write mode. It never changes its SDA drive while SCL is high.
- R12: While `rst_n` is low, all registers take their reset values, the bus logic returns to idle and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired line) |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Low three address bits |
| pins_i | input | 16 | External pin levels for the input registers |
| cfg_o | output | 64 | Writable registers 2 to 9, byte k is register 2+k |
| wr_stb_o | output | 8 | One-clock write strobe, bit k for register 2+k |

## Verification
The hardest case to reach is a pointer that walks past the end of the map. Auto-increment from 9, or from a command that loads 10 to 15, must land on entry 0. The bench reaches it by writing more bytes than the map holds and by reading from pointer 15 onward. It checks that the first byte reads as zero and the next as the low pin byte. The capture moment of the pin bytes is also hard to see from outside. The bench changes the pins while a byte is being shifted out and expects the old value in that byte and the new value only in the next one. Every one of the 128 seven-bit addresses is also swept against the strap value.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned PTR_W  = 4;

   typedef enum logic [2:0] {
      LS_IDLE,
      LS_ADDR,
      LS_ADDR_ACK,
      LS_WR_BYTE,
      LS_WR_ACK,
      LS_RD_BYTE,
      LS_RD_ACK,
      LS_PARK
   } link_state_e;
endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("i2cr_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] pipe_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) pipe_q[s] <= {WIDTH{RST_VAL}};
      end else begin
         pipe_q[0] <= d_i;
         for (int s = 1; s < int'(STAGES); s++) pipe_q[s] <= pipe_q[s-1];
      end
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2cr_link.sv
module i2cr_link
   import i2cr_pkg::*;
#(
   parameter logic [3:0] DEV_ID = 4'b1100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic [2:0]        strap_i,
   output logic              sda_oe_o,
   output logic              wr_evt_o,
   output logic              wr_cmd_o,
   output logic [BYTE_W-1:0] wr_byte_o,
   output logic              rd_evt_o,
   input  logic [BYTE_W-1:0] rd_byte_i
);
   localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

   link_state_e       state_q;
   logic              scl_d, sda_d;
   logic [3:0]        bit_cnt_q;
   logic [BYTE_W-1:0] shreg_q;
   logic              rd_mode_q;
   logic              cmd_pend_q;
   logic              mack_q;
   logic              sda_oe_q;

   logic start_c, stop_c, rise_c, fall_c, addr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
   assign rise_c   = scl_s & ~scl_d;
   assign fall_c   = ~scl_s & scl_d;
   assign addr_hit = (shreg_q[7:1] == {DEV_ID, strap_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= LS_IDLE;
         bit_cnt_q  <= '0;
         shreg_q    <= '0;
         rd_mode_q  <= 1'b0;
         cmd_pend_q <= 1'b0;
         mack_q     <= 1'b0;
         sda_oe_q   <= 1'b0;
      end else if (start_c) begin
         state_q   <= LS_ADDR;
         bit_cnt_q <= '0;
         sda_oe_q  <= 1'b0;
      end else if (stop_c) begin
         state_q  <= LS_IDLE;
         sda_oe_q <= 1'b0;
      end else begin
         unique case (state_q)
            LS_IDLE, LS_PARK: ;
            LS_ADDR: begin
               if (rise_c) begin
                  shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s};
                  bit_cnt_q <= bit_cnt_q + 4'd1;
               end else if (fall_c && bit_cnt_q == LAST_BIT) begin
                  if (addr_hit) begin
                     sda_oe_q   <= 1'b1;
                     rd_mode_q  <= shreg_q[0];
                     cmd_pend_q <= ~shreg_q[0];
                     state_q    <= LS_ADDR_ACK;
                  end else begin
                     state_q <= LS_PARK;
                  end
               end
            end
            LS_ADDR_ACK: begin
               if (fall_c) begin
                  bit_cnt_q <= '0;
                  if (rd_mode_q) begin
                     shreg_q  <= rd_byte_i;
                     sda_oe_q <= ~rd_byte_i[BYTE_W-1];
                     state_q  <= LS_RD_BYTE;
                  end else begin
                     sda_oe_q <= 1'b0;
                     state_q  <= LS_WR_BYTE;
                  end
               end
            end
            LS_WR_BYTE: begin
               if (rise_c) begin
                  shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s};
                  bit_cnt_q <= bit_cnt_q + 4'd1;
               end else if (fall_c && bit_cnt_q == LAST_BIT) begin
                  sda_oe_q <= 1'b1;
                  state_q  <= LS_WR_ACK;
               end
            end
            LS_WR_ACK: begin
               if (fall_c) begin
                  sda_oe_q   <= 1'b0;
                  bit_cnt_q  <= '0;
                  cmd_pend_q <= 1'b0;
                  state_q    <= LS_WR_BYTE;
               end
            end
            LS_RD_BYTE: begin
               if (rise_c) begin
                  bit_cnt_q <= bit_cnt_q + 4'd1;
               end else if (fall_c) begin
                  if (bit_cnt_q == LAST_BIT) begin
                     sda_oe_q <= 1'b0;
                     state_q  <= LS_RD_ACK;
                  end else begin
                     shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                     sda_oe_q <= ~shreg_q[BYTE_W-2];
                  end
               end
            end
            LS_RD_ACK: begin
               if (rise_c) begin
                  mack_q <= ~sda_s;
               end else if (fall_c) begin
                  if (mack_q) begin
                     shreg_q   <= rd_byte_i;
                     sda_oe_q  <= ~rd_byte_i[BYTE_W-1];
                     bit_cnt_q <= '0;
                     state_q   <= LS_RD_BYTE;
                  end else begin
                     state_q <= LS_PARK;
                  end
               end
            end
            default: state_q <= LS_IDLE;
         endcase
      end
   end

   assign sda_oe_o  = sda_oe_q;
   assign wr_evt_o  = ~start_c & ~stop_c & fall_c & (state_q == LS_WR_BYTE) & (bit_cnt_q == LAST_BIT);
   assign wr_cmd_o  = cmd_pend_q;
   assign wr_byte_o = shreg_q;
   assign rd_evt_o  = ~start_c & ~stop_c & fall_c &
                      (((state_q == LS_ADDR_ACK) & rd_mode_q) | ((state_q == LS_RD_ACK) & mack_q));

   AST_DRIVE_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && scl_d && !start_c && !stop_c) |=> $stable(sda_oe_q)); // R11
   AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LS_ADDR_ACK || state_q == LS_WR_ACK) |-> sda_oe_q); // R11
   AST_SILENT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LS_IDLE || state_q == LS_PARK) |-> !sda_oe_q); // R10
   AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      start_c |=> (state_q == LS_ADDR && bit_cnt_q == 4'd0)); // R2
endmodule

// File: rtl/i2cr_regs.sv
module i2cr_regs
   import i2cr_pkg::*;
#(
   parameter int unsigned PIN_W   = 16,
   parameter logic [7:0]  PSC_RST = 8'hFF,
   parameter logic [7:0]  PWM_RST = 8'h80,
   parameter logic [7:0]  SEL_RST = 8'h55
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [PIN_W-1:0]             pins_i,
   input  logic                         wr_evt_i,
   input  logic                         wr_cmd_i,
   input  logic [BYTE_W-1:0]            wr_byte_i,
   input  logic                         rd_evt_i,
   output logic [BYTE_W-1:0]            rd_byte_o,
   output logic [8*(4+PIN_W/4)-1:0]     cfg_o,
   output logic [(4+PIN_W/4)-1:0]       wr_stb_o
);
   localparam int unsigned NUM_IN  = PIN_W / 8;
   localparam int unsigned NUM_CFG = 4 + PIN_W / 4;
   localparam int unsigned NUM_REG = NUM_IN + NUM_CFG;
   localparam logic [PTR_W-1:0] LAST_IDX  = PTR_W'(NUM_REG - 1);
   localparam logic [PTR_W-1:0] FIRST_CFG = PTR_W'(NUM_IN);

   if (PIN_W % 8 != 0 || PIN_W == 0) begin : g_bad_pins
      $error("i2cr_regs: PIN_W must be a non-zero multiple of 8");
   end
   if (NUM_REG > (1 << PTR_W)) begin : g_bad_map
      $error("i2cr_regs: register map exceeds pointer range");
   end

   logic [PTR_W-1:0]  ptr_q;
   logic              ai_q;
   logic [BYTE_W-1:0] cfg_q [NUM_CFG];

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      return (p >= LAST_IDX) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         ai_q  <= 1'b0;
      end else if (wr_evt_i && wr_cmd_i) begin
         ptr_q <= wr_byte_i[PTR_W-1:0];
         ai_q  <= wr_byte_i[PTR_W];
      end else if ((wr_evt_i || rd_evt_i) && ai_q) begin
         ptr_q <= ptr_next(ptr_q);
      end
   end

   for (genvar g = 0; g < int'(NUM_CFG); g++) begin : g_cfg
      localparam logic [7:0] RST_V = (g < 4) ? (((g % 2) == 0) ? PSC_RST : PWM_RST) : SEL_RST;
      localparam logic [PTR_W-1:0] IDX = PTR_W'(NUM_IN + g);
      logic [BYTE_W-1:0] q;
      logic              stb_q;
      logic              hit;

      assign hit = wr_evt_i & ~wr_cmd_i & (ptr_q == IDX);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q     <= RST_V;
            stb_q <= 1'b0;
         end else begin
            stb_q <= hit;
            if (hit) q <= wr_byte_i;
         end
      end

      assign cfg_q[g]            = q;
      assign cfg_o[8*g +: 8]     = q;
      assign wr_stb_o[g]         = stb_q;

      AST_STB_CARRIES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
         stb_q |-> (q == $past(wr_byte_i))); // R5
   end

   always_comb begin
      rd_byte_o = '0;
      for (int k = 0; k < int'(NUM_IN); k++) begin
         if (ptr_q == PTR_W'(k)) rd_byte_o = pins_i[8*k +: 8];
      end
      for (int k = 0; k < int'(NUM_CFG); k++) begin
         if (ptr_q == PTR_W'(NUM_IN + k)) rd_byte_o = cfg_q[k];
      end
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb_o)); // R5
   AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_evt_i && rd_evt_i)); // R6
   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_evt_i || rd_evt_i) && !(wr_evt_i && wr_cmd_i) && ai_q && ptr_q >= LAST_IDX) |=> (ptr_q == '0)); // R6
   AST_RO_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt_i && !wr_cmd_i && (ptr_q < FIRST_CFG || ptr_q > LAST_IDX)) |=> (wr_stb_o == '0)); // R7
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
   parameter logic [3:0]  DEV_ID      = 4'b1100,
   parameter int unsigned PIN_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PIN_SYNC    = 1'b1,
   parameter logic [7:0]  PSC_RST     = 8'hFF,
   parameter logic [7:0]  PWM_RST     = 8'h80,
   parameter logic [7:0]  SEL_RST     = 8'h55
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scl_i,
   input  logic                     sda_i,
   output logic                     sda_oe_o,
   input  logic [2:0]               strap_i,
   input  logic [PIN_W-1:0]         pins_i,
   output logic [8*(4+PIN_W/4)-1:0] cfg_o,
   output logic [(4+PIN_W/4)-1:0]   wr_stb_o
);
   logic [1:0]       bus_s;
   logic [PIN_W-1:0] pins_s;
   logic             wr_evt, wr_cmd, rd_evt;
   logic [7:0]       wr_byte, rd_byte;

   i2cr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (bus_s)
   );

   if (PIN_SYNC) begin : g_pin_sync
      i2cr_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (pins_i),
         .q_o   (pins_s)
      );
   end else begin : g_pin_raw
      assign pins_s = pins_i;
   end

   i2cr_link #(.DEV_ID(DEV_ID)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (bus_s[1]),
      .sda_s     (bus_s[0]),
      .strap_i   (strap_i),
      .sda_oe_o  (sda_oe_o),
      .wr_evt_o  (wr_evt),
      .wr_cmd_o  (wr_cmd),
      .wr_byte_o (wr_byte),
      .rd_evt_o  (rd_evt),
      .rd_byte_i (rd_byte)
   );

   i2cr_regs #(
      .PIN_W   (PIN_W),
      .PSC_RST (PSC_RST),
      .PWM_RST (PWM_RST),
      .SEL_RST (SEL_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_i    (pins_s),
      .wr_evt_i  (wr_evt),
      .wr_cmd_i  (wr_cmd),
      .wr_byte_i (wr_byte),
      .rd_evt_i  (rd_evt),
      .rd_byte_o (rd_byte),
      .cfg_o     (cfg_o),
      .wr_stb_o  (wr_stb_o)
   );
endmodule

// File: tb/i2c_regbank_slave_tb.sv
module i2c_regbank_slave_tb;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 5;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [2:0]  strap = 3'b101;
   logic [15:0] pins_v = 16'h0000;
   logic        sda_oe;
   logic [63:0] cfg;
   logic [7:0]  stb;
   wire         sda_line = sda_m & ~sda_oe;

   int n_checks = 0;
   int n_fail   = 0;
   logic [7:0] model [16];
   int exp_cnt [8];
   int got_cnt [8];
   logic [3:0] bptr = 4'd0;
   logic       bai  = 1'b0;
   logic       prev_scl = 1'b1, prev_rst = 1'b0, prev_oe = 1'b0;
   logic [7:0] prev_stb = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_regbank_slave u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .sda_oe_o (sda_oe),
      .strap_i  (strap),
      .pins_i   (pins_v),
      .cfg_o    (cfg),
      .wr_stb_o (stb)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // R11 / R5 monitors: drive changes with SCL high, strobe width
   always @(negedge clk) begin
      if (rst_n && prev_rst && scl_m && prev_scl && (sda_oe !== prev_oe)) begin
         n_checks++; n_fail++;
         $display("FAIL R11: drive changed with SCL high, actual %0b expected %0b", sda_oe, prev_oe);
      end
      if (rst_n) begin
         for (int k = 0; k < 8; k++) begin
            if (stb[k]) got_cnt[k]++;
            if (stb[k] && prev_stb[k]) begin
               n_checks++; n_fail++;
               $display("FAIL R5: strobe %0d wider than one clock, actual 2 expected 1", k);
            end
         end
      end
      prev_scl = scl_m; prev_rst = rst_n; prev_oe = sda_oe; prev_stb = stb;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic model_reset();
      model[2] = 8'hFF; model[3] = 8'h80; model[4] = 8'hFF; model[5] = 8'h80;
      for (int k = 6; k < 10; k++) model[k] = 8'h55;
      bptr = 4'd0; bai = 1'b0;
   endtask

   function automatic logic [7:0] exp_rd(input logic [3:0] p);
      if (p == 4'd0) return pins_v[7:0];
      if (p == 4'd1) return pins_v[15:8];
      if (p <= 4'd9) return model[p];
      return 8'h00;
   endfunction

   task automatic adv();
      if (bai) bptr = (bptr >= 4'd9) ? 4'd0 : bptr + 4'd1;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
      end
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic read_byte(input logic mack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
      end
      sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q); sda_m = 1'b1;
   endtask

   task automatic check_cfg(input string req);
      for (int k = 0; k < 8; k++) check(req, cfg[8*k +: 8], model[2+k]);
   endtask

   task automatic check_stb(input string req);
      for (int k = 0; k < 8; k++) check(req, got_cnt[k], exp_cnt[k]);
   endtask

   task automatic write_regs(input logic [7:0] cmd, input int n, input logic [7:0] base,
                             input logic [7:0] step, input string req);
      logic ack;
      logic [7:0] d;
      bus_start();
      send_byte({4'hC, strap, 1'b0}, ack); check({req, " R1 addr ack"}, ack, 1);
      send_byte(cmd, ack); check({req, " R11 cmd ack"}, ack, 1);
      bptr = cmd[3:0]; bai = cmd[4];
      for (int k = 0; k < n; k++) begin
         d = 8'(base + step * k);
         send_byte(d, ack); check({req, " R7 data ack"}, ack, 1);
         if (bptr >= 4'd2 && bptr <= 4'd9) begin
            model[bptr] = d; exp_cnt[bptr-2]++;
         end
         adv();
      end
      bus_stop(); tick(4);
      check_cfg({req, " R5 contents"});
      check_stb({req, " R5 strobes"});
   endtask

   task automatic read_regs(input logic [7:0] cmd, input int n, input string req);
      logic ack;
      logic [7:0] b;
      bus_start();
      send_byte({4'hC, strap, 1'b0}, ack); check({req, " R1 addr ack"}, ack, 1);
      send_byte(cmd, ack); check({req, " R3 cmd ack"}, ack, 1);
      bptr = cmd[3:0]; bai = cmd[4];
      bus_start();
      send_byte({4'hC, strap, 1'b1}, ack); check({req, " R2 restart read ack"}, ack, 1);
      for (int k = 0; k < n; k++) begin
         read_byte(k != n - 1, b);
         check({req, " R8 read data"}, b, exp_rd(bptr));
         adv();
      end
      bus_stop();
   endtask

   initial begin : main
      logic ack;
      logic [7:0] b1, b2;
      for (int k = 0; k < 8; k++) begin exp_cnt[k] = 0; got_cnt[k] = 0; end
      for (int k = 0; k < 16; k++) model[k] = 8'h00;
      model_reset();
      pins_v = 16'hB6C3;
      tick(6); rst_n = 1'b1; tick(6);

      // R12 / R4: reset values
      check("R12 released", sda_oe, 0);
      check_cfg("R12 R4 reset values");

      // R2: clocked bits without any START are ignored
      scl_m = 1'b0; tick(Q);
      send_byte({4'hC, strap, 1'b0}, ack);
      check("R2 no START no ack", ack, 0);
      bus_stop(); tick(4);

      // R5 R6 R7: auto-increment sweep over the map with wrap
      for (int pass = 0; pass < 4; pass++) begin
         write_regs(8'h12, 11, 8'(pass * 37 + 3), 8'(29 + pass * 2), "R6 wr sweep");
         read_regs(8'h10, 12, "R6 rd sweep");
      end

      // R3 R6: no auto-increment, upper command bits discarded
      write_regs(8'hE5, 3, 8'h41, 8'h11, "R3 fixed ptr");
      read_regs(8'hE5, 3, "R3 fixed rd");

      // R7 R8: every pointer value, write then read
      for (int p = 0; p < 16; p++) begin
         write_regs(8'(p), 1, 8'(8'hA5 ^ p), 8'h00, "R7 ptr sweep");
         read_regs(8'(p), 1, "R8 ptr sweep");
      end

      // R6: auto-increment from 15 wraps to entry 0
      read_regs(8'h1F, 3, "R6 wrap from 15");
      write_regs(8'h1C, 7, 8'h90, 8'h01, "R6 wrap write from 12");

      // R1: all 7-bit addresses against the straps
      for (int a = 0; a < 128; a++) begin
         bus_start();
         send_byte({7'(a), 1'b0}, ack);
         check("R1 address sweep", ack, (7'(a) == {4'hC, strap}) ? 1 : 0);
         if (7'(a) != {4'hC, strap}) begin
            send_byte(8'h02, ack);
            check("R1 silent after miss", ack, 0);
         end
         bus_stop();
      end
      strap = 3'b010; tick(4);
      write_regs(8'h07, 1, 8'h3D, 8'h00, "R1 new strap");
      check_cfg("R1 after sweep");

      // R9: pin byte captured at the acknowledge edge
      pins_v = 16'h1E2D; tick(8);
      bus_start();
      send_byte({4'hC, strap, 1'b0}, ack);
      send_byte(8'h00, ack);
      bus_start();
      send_byte({4'hC, strap, 1'b1}, ack);
      fork
         read_byte(1'b1, b1);
         begin tick(30); pins_v = 16'h1E99; end
      join
      read_byte(1'b0, b2);
      bus_stop();
      check("R9 captured before change", b1, 8'h2D);
      check("R9 next byte sees change", b2, 8'h99);

      // R10: master NACK, then slave stays silent
      bus_start();
      send_byte({4'hC, strap, 1'b0}, ack);
      send_byte(8'h03, ack);
      bus_start();
      send_byte({4'hC, strap, 1'b1}, ack);
      read_byte(1'b0, b1);
      check("R10 data before nack", b1, model[3]);
      read_byte(1'b1, b2);
      check("R10 released after nack", b2, 8'hFF);
      check("R10 no drive", sda_oe, 0);
      bus_stop();

      // R2: START in the middle of a byte restarts address reception
      bus_start();
      for (int i = 0; i < 4; i++) begin
         sda_m = i[0]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
      end
      write_regs(8'h06, 1, 8'h6B, 8'h00, "R2 restart mid byte");

      // R12: reset in the middle of a write
      bus_start();
      send_byte({4'hC, strap, 1'b0}, ack);
      send_byte(8'h13, ack);
      send_byte(8'h3C, ack);
      exp_cnt[1]++;
      for (int i = 0; i < 4; i++) begin
         sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
      end
      rst_n = 1'b0; tick(3);
      check("R12 released in reset", sda_oe, 0);
      rst_n = 1'b1; tick(3);
      sda_m = 1'b1; bus_stop();
      model_reset();
      check_cfg("R12 defaults after reset");
      check_stb("R12 strobes");
      bus_start();
      send_byte({4'hC, strap, 1'b1}, ack);
      check("R3 read ack after reset", ack, 1);
      read_byte(1'b0, b1);
      check("R3 pointer reset to 0", b1, pins_v[7:0]);
      bus_stop(); tick(10);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule